// File: doc/BRIEF.md
# Multi-Region Relocating Access Guard

This block sits between a processor's memory port and the memory system and vets every load, store and instruction fetch before it is allowed through. It keeps four region descriptors, each made of a relocation base, a length limit and three independent rights (read, write, execute). The top bits of each program address pick a descriptor. The remaining bits are an offset that is compared with the descriptor's limit, and the descriptor's base is added to that offset to form the physical address. An access that passes both the range check and the rights check goes out with its physical address one cycle later. Any other access produces a fault code and never reaches memory.

Privileged software sets up the descriptors through a small configuration write port. A write made while the privilege input is low changes nothing and raises a distinct fault code. After reset every descriptor has a zero limit and no rights, so every access faults until a region has been set up. With several regions, a process can hold private code, data and stack areas and also a window onto memory shared with other processes. Because relocation is applied to every address, programs need no absolute addresses.

Top module: `seg_guard`

## Requirements
- R1: While reset is low, and after it is released, `mem_valid` is 0 and `fault` is 2'b00. With descriptors still in their reset state, every valid access of any kind to any slot reports `fault` 2'b01.
- R2: Results are registered and appear one cycle after the access is presented. In a cycle with `acc_valid` low and no rejected configuration write, the next cycle shows `mem_valid` 0 and `fault` 2'b00.
- R3: The slot is `acc_addr[31:30]` and the offset is `acc_addr[29:0]`. For a passing access, `mem_addr` equals the slot's base plus the zero-extended offset, modulo 2^32.
- R4: An offset greater than or equal to the slot's limit gives `fault` 2'b01 and `mem_valid` 0.
- R5: Rights bit 0 permits reads (`acc_kind` 2'b00), bit 1 permits writes (2'b01) and bit 2 permits fetches (2'b10). Read rights do not permit a fetch. Kind 2'b11 is never permitted. An in-range access without the right gives `fault` 2'b10 and `mem_valid` 0.
- R6: When an access is both out of range and lacks rights, the range fault 2'b01 is the one reported.
- R7: A configuration write with `cfg_we` and `cfg_priv` high updates the field chosen by `cfg_field` in slot `cfg_slot`: 2'b00 base (all 32 bits), 2'b01 limit (`cfg_wdata[29:0]`), 2'b10 rights (`cfg_wdata[2:0]`). Field 2'b11 changes nothing. The new value applies to accesses presented from the next cycle on. An access in the same cycle uses the old value.
- R8: A configuration write with `cfg_priv` low changes no descriptor, and the next cycle shows `fault` 2'b11. That code takes precedence over any access fault code. A coincident access that passes its checks still gets `mem_valid` and its address.
- R9: A write to one slot leaves the other slots' descriptors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously to clk |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| acc_addr | input | 32 | Program address: slot in [31:30], offset in [29:0] |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Issuer is in privileged mode |
| cfg_slot | input | 2 | Descriptor slot to write |
| cfg_field | input | 2 | 00 base, 01 limit, 10 rights, 11 none |
| cfg_wdata | input | 32 | Write data |
| mem_valid | output | 1 | Access granted, physical address valid |
| mem_addr | output | 32 | Relocated physical address |
| fault | output | 2 | 00 none, 01 out of range, 10 rights, 11 unprivileged write |

## Verification
The hardest cases to reach are the ones where two events fall in the same cycle. One is a privileged write that changes a descriptor while an access to that same slot is being checked. The other is a rejected write that coincides with a granted access, so the fault code and the grant must both appear. The bench drives these pairings on purpose. Around them it runs near-exhaustive sweeps: every slot and access kind at the offsets just below, at and above each limit, and every one of the eight rights patterns crossed with every kind. These sweeps also cover the precedence of the range fault over the rights fault, and address wrap past 2^32.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_RANGE = 2'b01,
    FLT_PERM  = 2'b10,
    FLT_PRIV  = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    FLD_BASE   = 2'b00,
    FLD_LIMIT  = 2'b01,
    FLD_RIGHTS = 2'b10,
    FLD_NONE   = 2'b11
  } cfg_field_e;

  localparam int RIGHTS_W = 3;
  localparam int RT_READ  = 0;
  localparam int RT_WRITE = 1;
  localparam int RT_EXEC  = 2;

endpackage

// File: rtl/seg_guard_desc.sv
// Descriptor storage: one base, limit and rights register set per slot.
module seg_guard_desc
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  localparam int SEL_W = $clog2(SLOTS),
  localparam int OFF_W = ADDR_W - SEL_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic                              cfg_priv,
  input  logic [SEL_W-1:0]                  cfg_slot,
  input  logic [1:0]                        cfg_field,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [SLOTS-1:0][ADDR_W-1:0]      base_o,
  output logic [SLOTS-1:0][OFF_W-1:0]       limit_o,
  output logic [SLOTS-1:0][RIGHTS_W-1:0]    rights_o,
  output logic                              reject_o
);

  logic accept;

  always_comb begin
    accept   = cfg_we & cfg_priv;
    reject_o = cfg_we & ~cfg_priv;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic                 hit;
    logic                 base_en, limit_en, rights_en;
    logic [ADDR_W-1:0]    base_q;
    logic [OFF_W-1:0]     limit_q;
    logic [RIGHTS_W-1:0]  rights_q;

    // per-field clock enables
    always_comb begin
      hit       = accept && (cfg_slot == SEL_W'(g));
      base_en   = hit && (cfg_field == FLD_BASE);
      limit_en  = hit && (cfg_field == FLD_LIMIT);
      rights_en = hit && (cfg_field == FLD_RIGHTS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q   <= '0;
        limit_q  <= '0;
        rights_q <= '0;
      end else begin
        if (base_en)   base_q   <= cfg_wdata;
        if (limit_en)  limit_q  <= cfg_wdata[OFF_W-1:0];
        if (rights_en) rights_q <= cfg_wdata[RIGHTS_W-1:0];
      end
    end

    assign base_o[g]   = base_q;
    assign limit_o[g]  = limit_q;
    assign rights_o[g] = rights_q;
  end

endmodule

// File: rtl/seg_guard_check.sv
// Combinational lookup, relocation, range and rights evaluation.
module seg_guard_check
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  localparam int SEL_W = $clog2(SLOTS),
  localparam int OFF_W = ADDR_W - SEL_W
) (
  input  logic                              acc_valid,
  input  logic [1:0]                        acc_kind,
  input  logic [ADDR_W-1:0]                 acc_addr,
  input  logic [SLOTS-1:0][ADDR_W-1:0]      base_i,
  input  logic [SLOTS-1:0][OFF_W-1:0]       limit_i,
  input  logic [SLOTS-1:0][RIGHTS_W-1:0]    rights_i,
  output logic                              grant_o,
  output logic [ADDR_W-1:0]                 phys_o,
  output logic [1:0]                        fault_o
);

  logic [SEL_W-1:0]    sel;
  logic [OFF_W-1:0]    off;
  logic [ADDR_W-1:0]   base_sel;
  logic [OFF_W-1:0]    limit_sel;
  logic [RIGHTS_W-1:0] rights_sel;
  logic                in_range;
  logic                allowed;

  always_comb begin
    sel        = acc_addr[ADDR_W-1 -: SEL_W];
    off        = acc_addr[OFF_W-1:0];
    base_sel   = base_i[sel];
    limit_sel  = limit_i[sel];
    rights_sel = rights_i[sel];
    in_range   = (off < limit_sel);
    phys_o     = base_sel + {{SEL_W{1'b0}}, off};

    case (acc_kind)
      ACC_READ:  allowed = rights_sel[RT_READ];
      ACC_WRITE: allowed = rights_sel[RT_WRITE];
      ACC_FETCH: allowed = rights_sel[RT_EXEC];
      default:   allowed = 1'b0;
    endcase

    grant_o = 1'b0;
    fault_o = FLT_NONE;
    if (acc_valid) begin
      if (!in_range)     fault_o = FLT_RANGE;
      else if (!allowed) fault_o = FLT_PERM;
      else               grant_o = 1'b1;
    end
  end

endmodule

// File: rtl/seg_guard.sv
// Top: descriptor store, access evaluation and registered result.
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  localparam int SEL_W = $clog2(SLOTS),
  localparam int OFF_W = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [SEL_W-1:0]  cfg_slot,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        fault
);

  logic [SLOTS-1:0][ADDR_W-1:0]   base_w;
  logic [SLOTS-1:0][OFF_W-1:0]    limit_w;
  logic [SLOTS-1:0][RIGHTS_W-1:0] rights_w;
  logic                           reject_w;
  logic                           grant_w;
  logic [ADDR_W-1:0]              phys_w;
  logic [1:0]                     chk_fault_w;

  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [1:0]        fault_d, fault_q;

  seg_guard_desc #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_priv  (cfg_priv),
    .cfg_slot  (cfg_slot),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_w),
    .limit_o   (limit_w),
    .rights_o  (rights_w),
    .reject_o  (reject_w)
  );

  seg_guard_check #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_check (
    .acc_valid (acc_valid),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .base_i    (base_w),
    .limit_i   (limit_w),
    .rights_i  (rights_w),
    .grant_o   (grant_w),
    .phys_o    (phys_w),
    .fault_o   (chk_fault_w)
  );

  // next-state: a rejected write outranks any access fault code
  always_comb begin
    valid_d = grant_w;
    addr_d  = grant_w ? phys_w : addr_q;
    fault_d = reject_w ? FLT_PRIV : chk_fault_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      fault_q <= fault_d;
    end
  end

  assign mem_valid = valid_q;
  assign mem_addr  = addr_q;
  assign fault     = fault_q;

endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic [1:0] acc_kind,
  input logic       cfg_we,
  input logic       cfg_priv,
  input logic       mem_valid,
  input logic [1:0] fault
);

  // R1: outputs quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!mem_valid && fault == 2'b00));

  // R2: idle cycle produces a quiet result next cycle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !(cfg_we && !cfg_priv)) |=> (!mem_valid && fault == 2'b00));

  // R4: range and rights faults never coexist with a grant
  p_fault_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == 2'b01 || fault == 2'b10) |-> !mem_valid);

  // R5: reserved kind is never granted
  p_rsvd_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b11) |=> !mem_valid);

  // R8: rejected write flagged next cycle
  p_priv_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> (fault == 2'b11));

  // R8: privilege code only follows a rejected write
  p_priv_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cfg_priv) |=> (fault != 2'b11));

endmodule

bind seg_guard seg_guard_chk u_seg_guard_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_kind  (acc_kind),
  .cfg_we    (cfg_we),
  .cfg_priv  (cfg_priv),
  .mem_valid (mem_valid),
  .fault     (fault)
);

// File: tb/test_seg_guard.sv
module test_seg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [1:0]  acc_kind;
  logic [31:0] acc_addr;
  logic        cfg_we;
  logic        cfg_priv;
  logic [1:0]  cfg_slot;
  logic [1:0]  cfg_field;
  logic [31:0] cfg_wdata;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [1:0]  fault;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] sh_base [4];
  logic [29:0] sh_lim  [4];
  logic [2:0]  sh_rt   [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard i_seg_guard (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_slot(cfg_slot),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .fault(fault)
  );

  function automatic logic right_ok(input logic [2:0] rt, input logic [1:0] k);
    case (k)
      2'b00:   return rt[0];
      2'b01:   return rt[1];
      2'b10:   return rt[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic av, input logic [1:0] kd, input logic [31:0] ad,
                      input logic we, input logic pr, input logic [1:0] sl,
                      input logic [1:0] fd, input logic [31:0] wd, input string req);
    logic        exp_mv;
    logic [1:0]  exp_f;
    logic [31:0] exp_a;
    int          s;
    logic [29:0] off;
    s = int'(ad[31:30]);
    off = ad[29:0];
    exp_mv = 1'b0; exp_f = 2'b00; exp_a = '0;
    if (av) begin
      if (off >= sh_lim[s])              exp_f = 2'b01;
      else if (!right_ok(sh_rt[s], kd))  exp_f = 2'b10;
      else begin exp_mv = 1'b1; exp_a = sh_base[s] + {2'b00, off}; end
    end
    if (we && !pr) exp_f = 2'b11;
    if (we && pr) begin
      case (fd)
        2'b00:   sh_base[sl] = wd;
        2'b01:   sh_lim[sl]  = wd[29:0];
        2'b10:   sh_rt[sl]   = wd[2:0];
        default: ;
      endcase
    end
    @(negedge clk);
    acc_valid = av; acc_kind = kd; acc_addr = ad;
    cfg_we = we; cfg_priv = pr; cfg_slot = sl; cfg_field = fd; cfg_wdata = wd;
    @(posedge clk);
    #1;
    vectors++;
    if (mem_valid !== exp_mv || fault !== exp_f || (exp_mv && mem_addr !== exp_a)) begin
      miscompares++;
      $display("FAIL %s: mem_valid=%0b/%0b fault=%0b/%0b mem_addr=%h/%h (actual/expected)",
               req, mem_valid, exp_mv, fault, exp_f, mem_addr, exp_a);
    end
  endtask

  task automatic acc(input logic [1:0] kd, input logic [31:0] ad, input string req);
    step(1'b1, kd, ad, 1'b0, 1'b0, 2'b00, 2'b00, 32'h0, req);
  endtask

  task automatic cfg(input logic [1:0] sl, input logic [1:0] fd, input logic [31:0] wd,
                     input logic pr, input string req);
    step(1'b0, 2'b00, 32'h0, 1'b1, pr, sl, fd, wd, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 0; acc_kind = 0; acc_addr = 0;
    cfg_we = 0; cfg_priv = 0; cfg_slot = 0; cfg_field = 0; cfg_wdata = 0;
    for (int i = 0; i < 4; i++) begin sh_base[i] = 0; sh_lim[i] = 0; sh_rt[i] = 0; end

    // R1: reset state of outputs
    repeat (2) @(posedge clk);
    #1;
    vectors++;
    if (mem_valid !== 1'b0 || fault !== 2'b00) begin
      miscompares++;
      $display("FAIL R1: mem_valid=%0b/0 fault=%0b/00 (actual/expected)", mem_valid, fault);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: unconfigured slots fault on every kind
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        acc(2'(k), {2'(s), 30'h0}, "R1");
        acc(2'(k), {2'(s), 30'h123}, "R1");
      end

    // R8: unprivileged writes are rejected and change nothing
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 3; f++) cfg(2'(s), 2'(f), 32'hFFFF_FFFF, 1'b0, "R8");
      acc(2'b00, {2'(s), 30'h0}, "R8");
    end

    // R7: privileged setup: r, rw, x, rwx
    for (int s = 0; s < 4; s++) begin
      cfg(2'(s), 2'b00, 32'h1000_0000 * (s + 1) + 32'h123 * s, 1'b1, "R7");
      cfg(2'(s), 2'b01, 32'h100 * (s + 1), 1'b1, "R7");
    end
    cfg(2'd0, 2'b10, 32'h1, 1'b1, "R7");
    cfg(2'd1, 2'b10, 32'h3, 1'b1, "R7");
    cfg(2'd2, 2'b10, 32'h4, 1'b1, "R7");
    cfg(2'd3, 2'b10, 32'h7, 1'b1, "R7");

    // R3 R4 R5 R6: boundary sweep per slot and kind
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        logic [29:0] lim;
        lim = sh_lim[s];
        acc(2'(k), {2'(s), 30'h0}, "R3 R5");
        acc(2'(k), {2'(s), lim - 30'h1}, "R3 R4");
        acc(2'(k), {2'(s), lim}, "R4 R6");
        acc(2'(k), {2'(s), lim + 30'h1}, "R4 R6");
        acc(2'(k), {2'(s), 30'h3FFF_FFFF}, "R4");
      end

    // R5 R6: all rights patterns on slot 2
    for (int r = 0; r < 8; r++) begin
      cfg(2'd2, 2'b10, 32'(r), 1'b1, "R7");
      for (int k = 0; k < 4; k++) begin
        acc(2'(k), {2'b10, 30'h5}, "R5");
        acc(2'(k), {2'b10, sh_lim[2]}, "R6");
      end
    end

    // R3: relocation wraps modulo 2^32
    cfg(2'd1, 2'b00, 32'hFFFF_FF00, 1'b1, "R7");
    cfg(2'd1, 2'b01, 32'h3FFF_FFFF, 1'b1, "R7");
    acc(2'b00, {2'b01, 30'h200}, "R3");
    acc(2'b01, {2'b01, 30'h3FFF_FFFE}, "R3");

    // R7: same-cycle write uses old limit, next cycle sees new one
    step(1'b1, 2'b00, {2'b00, 30'h0}, 1'b1, 1'b1, 2'd0, 2'b01, 32'h0, "R7");
    acc(2'b00, {2'b00, 30'h0}, "R7");
    // R9: other slots untouched by slot 0 change
    acc(2'b10, {2'b11, 30'h10}, "R9");
    acc(2'b01, {2'b01, 30'h10}, "R9");
    // R7: field 11 has no effect
    cfg(2'd3, 2'b11, 32'h0, 1'b1, "R7");
    acc(2'b00, {2'b11, 30'h20}, "R7");
    acc(2'b00, {2'b11, 30'h400}, "R7");

    // R8: rejected write alongside a granted access
    step(1'b1, 2'b00, {2'b11, 30'h4}, 1'b1, 1'b0, 2'd3, 2'b10, 32'h0, "R8");
    acc(2'b10, {2'b11, 30'h4}, "R8");
    // R8: rejected write alongside a range-faulting access
    step(1'b1, 2'b00, {2'b00, 30'h1}, 1'b1, 1'b0, 2'd0, 2'b01, 32'hFFFF, "R8");
    acc(2'b00, {2'b00, 30'h1}, "R8");

    // R2: idle cycles are quiet even with a bad address present
    step(1'b0, 2'b11, 32'hFFFF_FFFF, 1'b0, 1'b0, 2'd0, 2'b00, 32'h0, "R2");
    step(1'b0, 2'b00, 32'h0, 1'b0, 1'b1, 2'd0, 2'b00, 32'h0, "R2");

    @(negedge clk);
    acc_valid = 0; cfg_we = 0;
    finish_run();
  end
endmodule